// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block turns a stream of 32-bit words from a show-ahead FIFO into a standard I2S master bus. Everything runs on one master clock. The bit clock, word select and serial data are all derived from that clock. A clock-ratio input sets the bit clock, and a resolution input sets how many bits each channel slot carries. Only the low-order bits of each word reach the line.

The bus always carries two channels. The first word popped for a frame fills the left slot and the next word fills the right slot. When transmit is enabled from idle, the serializer first sends one frame of silence. It then pops two words per frame.

- If the FIFO has nothing at the start of a frame, that frame is sent as zeros.
- When transmit is cleared, the running frame finishes and the lines are then held low.

Top module: `i2s_tx_master`

## Requirements
- R1: After reset the bit clock runs continuously. Each high phase and each low phase lasts ratio+2 master clock cycles, with ratio the 8-bit configuration value.
- R2: Word select and serial data change only on the master clock edge at which the bit clock falls. A FIFO pop is requested only in the cycle just before such an edge. Data goes out MSB first.
- R3: A frame is two slots of W bits each. Word select is low for the left slot and high for the right slot. It switches one bit period before the MSB of each slot, so it already carries the next slot's value during the LSB of the current slot.
- R4: W equals the 6-bit resolution input, and the values 0 and anything above 32 act as 32. W is captured at the start of each frame. Of each 32-bit word only bits W-1..0 are sent, with bit W-1 first.
- R5: When transmit is enabled while idle, the first frame begins at the next bit-clock fall. That frame is all zeros, and no pop is requested during it.
- R6: In each later frame, one word is popped at the start of the left slot and another at the start of the right slot. The first goes to the left channel and the second to the right channel.
- R7: If the FIFO is empty when a data frame starts, the whole frame is zeros. No pop is requested in that frame, even if words arrive later within it.
- R8: If the left word was popped but the FIFO is empty when the right slot starts, the right slot is zeros and no pop is requested.
- R9: When transmit is cleared, the current frame completes and then word select and data are held low. Enabling again starts over with a zero frame.
- R10: The pop request is a single-cycle pulse. It is raised only while the FIFO reports data, and the word shown on the data input in that cycle is the one transmitted.
- R11: During and right after reset, the bit clock, word select, data and pop request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmit enable |
| ratioCfg | input | 8 | Bit clock ratio; half period is ratioCfg+2 master cycles |
| resCfg | input | 6 | Bits per channel slot (0 or >32 means 32) |
| fifoData | input | 32 | Head word of the show-ahead FIFO |
| fifoEmpty | input | 1 | FIFO has no word |
| fifoPop | output | 1 | Consume the head word this cycle |
| sclkOut | output | 1 | I2S bit clock |
| wsOut | output | 1 | I2S word select (low = left) |
| sdOut | output | 1 | I2S serial data |

## Verification
The bench builds the block with its default widths: 32-bit words, an 8-bit ratio and a 6-bit resolution. It drives ratio values 0, 1 and 2 and resolutions of 8, 16 and 32, plus the clamped settings 0 and 40. Frames therefore stay a few hundred master cycles long, which puts many frames within reach of one run.

These frames cover the zero frame, full pairs, an odd word count that leaves a right slot empty, and an empty start with words arriving mid-frame. They also cover a disable in mid-frame followed by a restart.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  // strobes from control to datapath, all valid on a bit-clock falling tick
  typedef struct packed {
    logic clear;    // slot register to zero
    logic load;     // capture FIFO word, aligned so slot MSB is on top
    logic shift;    // advance to next bit
    logic wsWrite;  // update word select
    logic wsNext;   // word select value for the coming bit
  } dpCtl_t;
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6,
  localparam int SH_W   = $clog2(WORD_W) + 1,
  localparam int IDX_W  = $clog2(2 * WORD_W) + 1,
  localparam int DIV_W  = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txEnable,
  input  logic [RATIO_W-1:0] ratioCfg,
  input  logic [RES_W-1:0]   resCfg,
  input  logic               fifoEmpty,
  output logic               fifoPop,
  output logic               sclkOut,
  output dpCtl_t             ctl,
  output logic [SH_W-1:0]    shamt
);
  logic [DIV_W-1:0] divCnt, halfLim;
  logic             sclkQ, tick, fallTick;
  logic             active, zeroFrame, leftPopped;
  logic [IDX_W-1:0] idx, lastIdx, newIdx, n1, twoW;
  logic [SH_W-1:0]  slotW, effRes, newW;
  logic             frameEnd, rightStart;
  logic             startZero, stayIdle, frameRestart, goIdle, toRight, midShift;
  logic             popLeft, popRight;

  assign halfLim  = DIV_W'(ratioCfg) + DIV_W'(1);
  assign tick     = (divCnt >= halfLim);
  assign fallTick = tick & sclkQ;
  assign sclkOut  = sclkQ;

  assign effRes = ((resCfg == '0) || (int'(resCfg) > WORD_W)) ? SH_W'(WORD_W) : SH_W'(resCfg);

  assign lastIdx    = IDX_W'({slotW, 1'b0}) - IDX_W'(1);
  assign frameEnd   = (idx == lastIdx);
  assign rightStart = ((idx + IDX_W'(1)) == IDX_W'(slotW));

  assign startZero    = fallTick & ~active & txEnable;
  assign stayIdle     = fallTick & ~active & ~txEnable;
  assign frameRestart = fallTick & active & frameEnd & txEnable;
  assign goIdle       = fallTick & active & frameEnd & ~txEnable;
  assign toRight      = fallTick & active & ~frameEnd & rightStart;
  assign midShift     = fallTick & active & ~frameEnd & ~rightStart;

  assign popLeft  = frameRestart & ~fifoEmpty;
  assign popRight = toRight & ~zeroFrame & leftPopped & ~fifoEmpty;
  assign fifoPop  = popLeft | popRight;

  // position and width of the bit that starts after this tick
  assign newIdx = (startZero | frameRestart) ? '0 : idx + IDX_W'(1);
  assign newW   = (startZero | frameRestart) ? effRes : slotW;
  assign n1     = newIdx + IDX_W'(1);
  assign twoW   = IDX_W'({newW, 1'b0});
  assign shamt  = SH_W'(WORD_W) - newW;

  always_comb begin
    ctl         = '0;
    ctl.wsWrite = fallTick;
    ctl.clear   = startZero | stayIdle | goIdle | (frameRestart & fifoEmpty) | (toRight & ~popRight);
    ctl.load    = popLeft | popRight;
    ctl.shift   = midShift;
    // word select leads the data by one bit period
    if (stayIdle | goIdle) ctl.wsNext = 1'b0;
    else if (n1 == twoW)   ctl.wsNext = 1'b0;
    else                   ctl.wsNext = (n1 >= IDX_W'(newW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      sclkQ  <= ~sclkQ;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      zeroFrame  <= 1'b0;
      leftPopped <= 1'b0;
      idx        <= '0;
      slotW      <= SH_W'(WORD_W);
    end else if (startZero) begin
      active     <= 1'b1;
      zeroFrame  <= 1'b1;
      leftPopped <= 1'b0;
      idx        <= '0;
      slotW      <= effRes;
    end else if (frameRestart) begin
      zeroFrame  <= 1'b0;
      leftPopped <= popLeft;
      idx        <= '0;
      slotW      <= effRes;
    end else if (goIdle) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (toRight | midShift) begin
      idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/i2s_tx_dp.sv
module i2s_tx_dp
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SH_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [SH_W-1:0]   shamt,
  input  logic [WORD_W-1:0] fifoData,
  output logic              wsOut,
  output logic              sdOut
);
  logic [WORD_W-1:0] slotReg;
  logic              wsQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotReg <= '0;
      wsQ     <= 1'b0;
    end else begin
      if (ctl.clear)      slotReg <= '0;
      else if (ctl.load)  slotReg <= fifoData << shamt;
      else if (ctl.shift) slotReg <= slotReg << 1;
      if (ctl.wsWrite)    wsQ <= ctl.wsNext;
    end
  end

  assign sdOut = slotReg[WORD_W-1];
  assign wsOut = wsQ;
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6,
  localparam int SH_W   = $clog2(WORD_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txEnable,
  input  logic [RATIO_W-1:0] ratioCfg,
  input  logic [RES_W-1:0]   resCfg,
  input  logic [WORD_W-1:0]  fifoData,
  input  logic               fifoEmpty,
  output logic               fifoPop,
  output logic               sclkOut,
  output logic               wsOut,
  output logic               sdOut
);
  dpCtl_t          ctl;
  logic [SH_W-1:0] shamt;

  i2s_tx_ctrl #(.WORD_W(WORD_W), .RATIO_W(RATIO_W), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .ratioCfg(ratioCfg),
    .resCfg(resCfg), .fifoEmpty(fifoEmpty), .fifoPop(fifoPop),
    .sclkOut(sclkOut), .ctl(ctl), .shamt(shamt)
  );

  i2s_tx_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .shamt(shamt),
    .fifoData(fifoData), .wsOut(wsOut), .sdOut(sdOut)
  );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic fifoPop,
  input logic fifoEmpty,
  input logic sclkOut,
  input logic wsOut,
  input logic sdOut
);
  // R10
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |-> !fifoEmpty);
  // R10
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |=> !fifoPop);
  // R2
  pop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |=> $fell(sclkOut));
  // R2
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wsOut) |-> $fell(sclkOut));
  // R2
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdOut) |-> $fell(sclkOut));
endmodule

bind i2s_tx_master i2s_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fifoPop(fifoPop), .fifoEmpty(fifoEmpty),
  .sclkOut(sclkOut), .wsOut(wsOut), .sdOut(sdOut)
);

// File: tb/i2s_tx_master_bench.sv
module i2s_tx_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txEnable = 1'b0;
  logic [7:0]  ratioCfg = 8'd2;
  logic [5:0]  resCfg = 6'd16;
  logic [31:0] fifoData = '0;
  logic        fifoEmpty = 1'b1;
  logic        fifoPop, sclkOut, wsOut, sdOut;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] q[$];

  // behavioural reference state
  int mDiv = 0, mIdx = 0, mW = 32;
  bit mSclk = 0, mAct = 0, mZf = 0, mPopped = 0;
  logic [31:0] mLeft = '0, mRight = '0;

  always #4 clk = ~clk;

  i2s_tx_master u_i2s_tx_master (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .ratioCfg(ratioCfg),
    .resCfg(resCfg), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoPop(fifoPop), .sclkOut(sclkOut), .wsOut(wsOut), .sdOut(sdOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic refresh();
    fifoEmpty = (q.size() == 0);
    fifoData  = fifoEmpty ? 32'h0 : q[0];
  endtask

  task automatic push(input logic [31:0] w);
    q.push_back(w);
    refresh();
  endtask

  function automatic int effW(input int r);
    return (r == 0 || r > 32) ? 32 : r;
  endfunction

  task automatic step(input string tag);
    bit tickE, fallE, popE;
    int nDiv, nIdx, nW;
    bit nSclk, nAct, nZf, nPopped;
    logic [31:0] nLeft, nRight;
    bit expWs, expSd;
    int ch, p;
    logic [31:0] wd;
    @(negedge clk);
    tickE = (mDiv >= int'(ratioCfg) + 1);
    fallE = tickE && mSclk;
    nDiv = tickE ? 0 : mDiv + 1;
    nSclk = tickE ? !mSclk : mSclk;
    nIdx = mIdx; nW = mW; nAct = mAct; nZf = mZf; nPopped = mPopped;
    nLeft = mLeft; nRight = mRight; popE = 0;
    if (fallE) begin
      if (!mAct) begin
        if (txEnable) begin
          nAct = 1; nZf = 1; nIdx = 0; nW = effW(resCfg); nPopped = 0;
          nLeft = 0; nRight = 0;
        end
      end else if (mIdx == 2 * mW - 1) begin
        if (txEnable) begin
          nIdx = 0; nZf = 0; nW = effW(resCfg); nRight = 0;
          if (q.size() > 0) begin popE = 1; nLeft = q[0]; nPopped = 1; end
          else begin nLeft = 0; nPopped = 0; end
        end else begin
          nAct = 0; nIdx = 0;
        end
      end else begin
        nIdx = mIdx + 1;
        if (nIdx == mW) begin
          if (!mZf && mPopped && q.size() > 0) begin popE = 1; nRight = q[0]; end
          else nRight = 0;
        end
      end
    end
    check(fifoPop === popE, {tag, " R10"}, "fifoPop", int'(fifoPop), int'(popE));
    @(posedge clk); #1;
    mDiv = nDiv; mSclk = nSclk; mIdx = nIdx; mW = nW; mAct = nAct; mZf = nZf;
    mPopped = nPopped; mLeft = nLeft; mRight = nRight;
    if (popE) begin void'(q.pop_front()); refresh(); end
    if (mAct) begin
      expWs = (((mIdx + 1) % (2 * mW)) >= mW);
      ch = (mIdx >= mW) ? 1 : 0;
      p  = mIdx % mW;
      wd = ch ? mRight : mLeft;
      expSd = wd[mW - 1 - p];
    end else begin
      expWs = 0; expSd = 0;
    end
    check(sclkOut === mSclk, {tag, " R1"}, "sclkOut", int'(sclkOut), int'(mSclk));
    check(wsOut === expWs, {tag, " R3"}, "wsOut", int'(wsOut), int'(expWs));
    check(sdOut === expSd, tag, "sdOut", int'(sdOut), int'(expSd));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    // R11 reset state
    check(sclkOut === 1'b0, "R11", "sclkOut", int'(sclkOut), 0);
    check(wsOut === 1'b0, "R11", "wsOut", int'(wsOut), 0);
    check(sdOut === 1'b0, "R11", "sdOut", int'(sdOut), 0);
    check(fifoPop === 1'b0, "R11", "fifoPop", int'(fifoPop), 0);
    rst_n = 1'b1;
    run(20, "R11 idle after reset");

    // zero frame, pairs, odd word count, then underrun frames
    ratioCfg = 8'd2; resCfg = 6'd16;
    push(32'h0000_A5C3); push(32'h0000_1234); push(32'hFFFF_8001);
    push(32'h0000_7FFE); push(32'h0000_0F0F);
    txEnable = 1'b1;
    run(1700, "R5 R6 R8 R7 R2");

    // disable mid-frame, finish frame, idle, then restart
    run(100, "R9 pre");
    txEnable = 1'b0;
    run(700, "R9 drain");
    push(32'hDEAD_BEEF); push(32'h0123_4567);
    ratioCfg = 8'd0; resCfg = 6'd32;
    run(50, "R9 idle holds");
    txEnable = 1'b1;
    run(900, "R9 R5 restart");

    // small resolution: upper bits of each word dropped
    txEnable = 1'b0;
    run(300, "R9 stop");
    ratioCfg = 8'd1; resCfg = 6'd8;
    push(32'hABCD_EF5A); push(32'h1234_56C3); push(32'hFFFF_FF00);
    push(32'h0000_0081);
    txEnable = 1'b1;
    run(700, "R4 R2 res8");

    // clamped resolutions
    txEnable = 1'b0;
    run(300, "R9 stop2");
    resCfg = 6'd0;
    push(32'h8000_0001); push(32'h4000_0002);
    txEnable = 1'b1;
    run(900, "R4 res0");
    resCfg = 6'd40;
    push(32'hC001_0003); push(32'h7FFF_FFFE);
    run(800, "R4 res40");

    // empty at frame start, words appear mid-frame
    txEnable = 1'b0;
    run(800, "R9 stop3");
    ratioCfg = 8'd0; resCfg = 6'd16;
    txEnable = 1'b1;
    run(200, "R7 empty start");
    push(32'h0000_AAAA); push(32'h0000_5555);
    run(600, "R7 late data R6");

    txEnable = 1'b0;
    run(400, "R9 end");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule